// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system reach an external asynchronous static RAM of 512K words by 16 bits. A client hands it one word access at a time over a valid/ready handshake: a 19-bit word address, a direction bit and, for stores, a 16-bit word. The controller then drives the memory's active-low select, output-enable and write-enable strobes, the address bus and a split tri-state data bus (drive value, drive enable, sampled input). Loads come back as a word with a one-cycle valid strobe.

Every phase of an access lasts a whole number of clock cycles. The phase lengths come from nanosecond timing parameters, rounded up against the clock-period parameter, with at least one cycle per phase. Stores pulse the write strobe while select and address stay still and output-enable stays high. After every load, the controller waits out a turnaround interval before it may drive the data bus again, so the memory has released the bus first. Between accesses the memory is deselected.

Top module: `sram_ctl`

## Requirements
- R1: After reset, select, output-enable and write-enable are high (1), the data bus driver is off (0), the request ready is high and the response valid is low.
- R2: A request is taken at a rising edge where valid and ready are both high. From the next cycle, ready stays low until the access has finished.
- R3: While select is low, the address bus keeps the address that was accepted for that access.
- R4: A load asserts the response valid for exactly one cycle, ACC+2 negative clock edges after the accepting edge, where ACC is the access cycle count.
- R5: In a store, write-enable is low for exactly WP cycles, and for all of those cycles select is low and output-enable is high.
- R6: The data bus driver is on when write-enable rises, and it is never on while output-enable is low.
- R7: After output-enable rises at the end of a load, at least TA+1 cycles pass before the data bus driver turns on again, where TA is the turnaround cycle count.
- R8: Each phase count is ceil(time_ns / CLK_NS) with a minimum of 1. The store setup phase is stretched so that setup plus pulse covers the data-setup time.
- R9: A load from an address returns the word most recently stored there, including at the lowest and highest addresses.
- R10: Whenever ready is high, the memory is deselected (select high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Store data |
| rsp_valid | output | 1 | Load data valid, one cycle |
| rsp_rdata | output | 16 | Load data |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_o | output | 16 | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus sampled value |

## Verification
The bench builds the controller with a 10 ns clock and deliberately slow timing values: 25 ns access, 17 ns write pulse, 5 ns data setup and 14 ns turnaround. These give three access cycles, two pulse cycles and two turnaround cycles. With these settings, the multi-cycle down-counting in each phase, the rounding up of times that are not whole clock periods, and the minimum-of-one rule for setup are all exercised, none of which a one-cycle configuration would reach. Back-to-back loads and stores test the turnaround gap against the bus-contention check in the memory model.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } state_e;

    // Round a time up to whole clock periods, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= CW'(1));

    // R8
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    logic [AW-1:0] addr_d;
    logic [DW-1:0] data_d;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (take) begin
            addr_d = addr_in;
            data_d = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW        = 19,
    parameter int unsigned DW        = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_ACC_NS  = 10,
    parameter int unsigned T_WP_NS   = 7,
    parameter int unsigned T_DS_NS   = 5,
    parameter int unsigned T_TURN_NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned DS_CYC   = ns_to_cyc(T_DS_NS, CLK_NS);
    localparam int unsigned SU_CYC   = (DS_CYC > WP_CYC) ? (DS_CYC - WP_CYC) : 1;
    localparam int unsigned TA_CYC   = ns_to_cyc(T_TURN_NS, CLK_NS);
    localparam int unsigned MAX_AW   = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
    localparam int unsigned MAX_ST   = (SU_CYC > TA_CYC) ? SU_CYC : TA_CYC;
    localparam int unsigned MAX_CYC  = (MAX_AW > MAX_ST) ? MAX_AW : MAX_ST;
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e        st;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
        logic          ready;
        logic          rsp_valid;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          take;

    assign take = (c_q.st == ST_IDLE) && req_valid && c_q.ready;

    sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_o)
    );

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = CW'(1);
        unique case (c_q.st)
            ST_IDLE: begin
                if (take) begin
                    c_d.ready = 1'b0;
                    c_d.ce_n  = 1'b0;
                    if (req_we) begin
                        c_d.st    = ST_WR_SETUP;
                        c_d.dq_oe = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = CW'(SU_CYC);
                    end else begin
                        c_d.st = ST_RD_SETUP;
                    end
                end
            end
            ST_RD_SETUP: begin
                c_d.st   = ST_RD_WAIT;
                c_d.oe_n = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = CW'(ACC_CYC);
            end
            ST_RD_WAIT: begin
                if (tmr_last) begin
                    c_d.st        = ST_RD_CAPTURE;
                    c_d.rdata     = mem_dq_i;
                    c_d.rsp_valid = 1'b1;
                    c_d.ce_n      = 1'b1;
                    c_d.oe_n      = 1'b1;
                end
            end
            ST_RD_CAPTURE: begin
                c_d.st   = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CW'(TA_CYC);
            end
            ST_TURN: begin
                if (tmr_last) begin
                    c_d.st    = ST_IDLE;
                    c_d.ready = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_last) begin
                    c_d.st   = ST_WR_PULSE;
                    c_d.we_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WP_CYC);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    c_d.st   = ST_WR_HOLD;
                    c_d.we_n = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                c_d.st    = ST_IDLE;
                c_d.ce_n  = 1'b1;
                c_d.dq_oe = 1'b0;
                c_d.ready = 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q           <= '0;
            c_q.st        <= ST_IDLE;
            c_q.ce_n      <= 1'b1;
            c_q.oe_n      <= 1'b1;
            c_q.we_n      <= 1'b1;
            c_q.ready     <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready = c_q.ready;
    assign rsp_valid = c_q.rsp_valid;
    assign rsp_rdata = c_q.rdata;
    assign mem_ce_n  = c_q.ce_n;
    assign mem_oe_n  = c_q.oe_n;
    assign mem_we_n  = c_q.we_n;
    assign mem_dq_oe = c_q.dq_oe;

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R4
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R6
    drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    drive_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R10
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int unsigned CLK_NS = 10;
    localparam int unsigned ACC_NS = 25;
    localparam int unsigned WP_NS  = 17;
    localparam int unsigned DS_NS  = 5;
    localparam int unsigned TA_NS  = 14;

    function automatic int unsigned cyc_of(input int unsigned t);
        int unsigned c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c == 0) ? 1 : c;
    endfunction

    localparam int unsigned ACC_E = (ACC_NS + CLK_NS - 1) / CLK_NS;
    localparam int unsigned WP_E  = (WP_NS + CLK_NS - 1) / CLK_NS;
    localparam int unsigned TA_E  = (TA_NS + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i, mdl_val;

    always #5 clk = ~clk;

    sram_ctl #(
        .CLK_NS(CLK_NS), .T_ACC_NS(ACC_NS), .T_WP_NS(WP_NS),
        .T_DS_NS(DS_NS), .T_TURN_NS(TA_NS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Behavioural memory following the select/enable truth table.
    logic [15:0] mdl   [int unsigned];
    logic [15:0] refm  [int unsigned];
    logic        mdl_drive;

    always @* begin
        mdl_val = mdl.exists(32'(mem_addr)) ? mdl[32'(mem_addr)] : 16'h0000;
    end
    assign mdl_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i  = mdl_drive ? mdl_val : 16'h0000;

    int unsigned total = 0, bad = 0;
    int unsigned cyc = 0, we_lo = 0, t_oe = 0;
    int unsigned contention = 0, addr_err = 0, idle_err = 0;
    logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dq = 1'b0, seen_rd = 1'b0;
    logic [18:0] cur_addr = '0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Bus monitor at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mdl_drive && mem_dq_oe) contention++;
            if (!mem_ce_n && mem_addr != cur_addr) addr_err++;
            if (req_ready && !mem_ce_n) idle_err++;
            if (!mem_we_n) we_lo++;
            if (mem_we_n && !prev_we) begin
                chk(we_lo == WP_E, "R5 write pulse cycles", we_lo, WP_E);
                chk(mem_dq_oe == 1'b1, "R6 driver on at WE rise", mem_dq_oe, 1);
                if (!mem_ce_n && mem_dq_oe) mdl[32'(mem_addr)] = mem_dq_o;
                we_lo = 0;
            end
            if (mem_oe_n && !prev_oe) begin
                t_oe = cyc;
                seen_rd = 1'b1;
            end
            if (mem_dq_oe && !prev_dq && seen_rd)
                chk((cyc - t_oe) >= TA_E + 1, "R7 turnaround gap", cyc - t_oe, TA_E + 1);
            prev_we = mem_we_n;
            prev_oe = mem_oe_n;
            prev_dq = mem_dq_oe;
        end
    end

    task automatic issue(input bit we, input logic [18:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        cur_addr = a;
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [15:0] d);
        issue(1'b1, a, d);
        refm[32'(a)] = d;
    endtask

    task automatic do_read(input logic [18:0] a);
        int unsigned n;
        logic [15:0] e;
        issue(1'b0, a, 16'h0);
        n = 1;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        e = refm.exists(32'(a)) ? refm[32'(a)] : 16'h0000;
        chk(n == cyc_of(ACC_NS) + 2, "R4/R8 read latency", n, cyc_of(ACC_NS) + 2);
        chk(rsp_rdata == e, "R9 readback data", rsp_rdata, e);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4 single-cycle valid", rsp_valid, 0);
    endtask

    initial begin
        logic [18:0] a;
        logic [15:0] d;
        logic [18:0] list [8];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(mem_dq_oe == 1'b0, "R1 driver off in reset", mem_dq_oe, 0);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
            {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;

        // Directed corners: extreme addresses, read of a fresh location
        do_read(19'h00123);
        do_write(19'h00000, 16'hA5A5);
        do_write(19'h7FFFF, 16'h5A5A);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        // Read then write right away: turnaround (R7)
        do_read(19'h00000);
        do_write(19'h00000, 16'hFFFF);
        do_read(19'h00000);
        // Overwrite same address (R9)
        do_write(19'h12345, 16'h1111);
        do_write(19'h12345, 16'h2222);
        do_read(19'h12345);

        // Random write-then-readback, batches of back-to-back writes then reads
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 8; i++) begin
                a = 19'($urandom);
                d = 16'($urandom);
                list[i] = a;
                do_write(a, d);
            end
            for (int i = 0; i < 8; i++) do_read(list[i]);
        end
        // Interleaved random mix
        for (int i = 0; i < 40; i++) begin
            a = 19'($urandom) & 19'h0003F;
            if ($urandom % 2) do_write(a, 16'($urandom));
            else              do_read(a);
        end
        repeat (4) @(negedge clk);

        chk(contention == 0, "R6 no bus contention", contention, 0);
        chk(addr_err == 0, "R3 address held during select", addr_err, 0);
        chk(idle_err == 0, "R10 deselected when ready", idle_err, 0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        report();
    end

endmodule